// File: doc/BRIEF.md
# Bidirectional Segment Driver Shift and Latch Core

This block is the digital core of a dot-matrix LCD segment driver. It holds two independent serial chains of 40 bits each. Chain 0 feeds segments 0 to 39 and chain 1 feeds segments 40 to 79. A controller sends serial data one bit per falling edge of a shift strobe. When a row is complete, a falling edge of a latch strobe copies all 80 chain bits into a display latch.

Each chain has its own direction input, which picks the travel direction. The same input decides which of the chain's two end pins takes serial data and which one presents the bit leaving the chain. The pin that is not driving is marked with a low output enable.

Each latched bit is combined with an alternation input to give a 2-bit level-select code per segment. The analog output stage turns that code into one of four drive voltages. All external inputs are oversampled by a fast system clock through two-flop synchronizers. Falling strobe edges become single-cycle pulses.

Top module: `seg_shift_latch`

## Requirements
- R1: While `rst` is high, both chains and the display latch are cleared. Every segment code then shows the non-select level for the current alternation value: 2'b11 with `alt_i`=0 and 2'b10 with `alt_i`=1.
- R2: With a chain's direction bit at 0, the bit on its low pin enters the lowest segment of that chain on each shift strobe falling edge, and every stored bit moves one segment upward. After 40 shifts the first bit sent sits in the chain's highest segment.
- R3: With a chain's direction bit at 1, the bit on its high pin enters the highest segment, and stored bits move one segment downward. After 40 shifts the first bit sent sits in the chain's lowest segment.
- R4: With direction 0, `hi_oe_o`=1, `lo_oe_o`=0, and `hi_out_o` carries the chain's highest bit. With direction 1, `lo_oe_o`=1, `hi_oe_o`=0, and `lo_out_o` carries the chain's lowest bit.
- R5: A latch strobe falling edge copies all 80 chain bits into the display latch. Shifting afterwards leaves the segment codes unchanged until the next latch edge.
- R6: Segment i's code sits at `seg_code_o[2i+1:2i]`. For a latched 1 it is 2'b00 with alternation 1 and 2'b01 with alternation 0. For a latched 0 it is 2'b10 with alternation 1 and 2'b11 with alternation 0.
- R7: A change of `alt_i` alone, with no latch edge, changes every segment code to the level given by R6 for the held latch contents.
- R8: The two chains operate independently, each in its own direction, at the same time.
- R9: A change of a direction bit leaves that chain's stored contents unchanged. The new direction applies from the next shift edge and switches the output pin and enable at once.
- R10: When shift and latch falling edges land in the same system clock cycle, the latch receives the chain contents from before that shift.
- R11: Each strobe acts only on its falling edge. A rising edge does not shift or latch, and each falling edge moves a chain by exactly one position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| shift_stb_i | input | 1 | Shift strobe; acts on its falling edge |
| latch_stb_i | input | 1 | Latch strobe; acts on its falling edge |
| alt_i | input | 1 | Alternation input |
| dir_i | input | NUM_CHAINS | Per-chain direction: 0 moves data upward, 1 moves it downward |
| lo_in_i | input | NUM_CHAINS | Serial input at the low end of each chain (used when direction is 0) |
| hi_in_i | input | NUM_CHAINS | Serial input at the high end of each chain (used when direction is 1) |
| lo_out_o | output | NUM_CHAINS | Lowest bit of each chain |
| hi_out_o | output | NUM_CHAINS | Highest bit of each chain |
| lo_oe_o | output | NUM_CHAINS | Output enable for the low-end pin |
| hi_oe_o | output | NUM_CHAINS | Output enable for the high-end pin |
| seg_code_o | output | 2*NUM_CHAINS*CHAIN_LEN | 2-bit level code per segment |

## Verification
A shift pulse and a latch pulse can fall in the same system clock cycle. Whether the latch then receives the pre-shift or the post-shift chain contents is the subtle point. The bench provokes this by releasing both strobes in the same time step, so both pass through identical synchronizers and their edge pulses coincide. It expects segment codes built from the model state before that shift. It then latches again and expects the shifted contents. A second overlap, a latch falling edge while the shift strobe is still high, confirms that no rising edge moves data.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    LVL_SEL_HI  = 2'b00,
    LVL_SEL_LO  = 2'b01,
    LVL_NSEL_HI = 2'b10,
    LVL_NSEL_LO = 2'b11
  } lvl_e;

  function automatic lvl_e lvl_code(input logic on, input logic alt);
    if (on) return alt ? LVL_SEL_HI : LVL_SEL_LO;
    else    return alt ? LVL_NSEL_HI : LVL_NSEL_LO;
  endfunction
endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end
endmodule

// File: rtl/ssl_fall_det.sv
module ssl_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);
  logic prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end
  assign fall = prev & ~lvl;
endmodule

// File: rtl/ssl_chain.sv
module ssl_chain #(
  parameter int LEN = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           dir,
  input  logic           lo_in,
  input  logic           hi_in,
  output logic [LEN-1:0] q,
  output logic           lo_out,
  output logic           hi_out,
  output logic           lo_oe,
  output logic           hi_oe
);
  logic din;
  assign din = dir ? hi_in : lo_in;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (step) begin
      if (dir) q <= {din, q[LEN-1:1]};
      else     q <= {q[LEN-2:0], din};
    end
  end

  assign lo_out = q[0];
  assign hi_out = q[LEN-1];
  assign lo_oe  = dir;
  assign hi_oe  = ~dir;
endmodule

// File: rtl/ssl_level_enc.sv
module ssl_level_enc
  import seg_pkg::*;
#(
  parameter int N = 80
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alt,
  input  logic [N-1:0]   lat,
  output logic [2*N-1:0] code
);
  for (genvar i = 0; i < N; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) code[2*i +: 2] <= lvl_code(1'b0, alt);
      else     code[2*i +: 2] <= lvl_code(lat[i], alt);
    end
  end
endmodule

// File: rtl/seg_shift_latch.sv
module seg_shift_latch #(
  parameter int CHAIN_LEN  = 40,
  parameter int NUM_CHAINS = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              shift_stb_i,
  input  logic                              latch_stb_i,
  input  logic                              alt_i,
  input  logic [NUM_CHAINS-1:0]             dir_i,
  input  logic [NUM_CHAINS-1:0]             lo_in_i,
  input  logic [NUM_CHAINS-1:0]             hi_in_i,
  output logic [NUM_CHAINS-1:0]             lo_out_o,
  output logic [NUM_CHAINS-1:0]             hi_out_o,
  output logic [NUM_CHAINS-1:0]             lo_oe_o,
  output logic [NUM_CHAINS-1:0]             hi_oe_o,
  output logic [2*NUM_CHAINS*CHAIN_LEN-1:0] seg_code_o
);
  localparam int NSEG = NUM_CHAINS * CHAIN_LEN;
  localparam int SW   = 3 + 3 * NUM_CHAINS;

  logic [SW-1:0]         sync_q;
  logic                  shift_s, latch_s, alt_s;
  logic [NUM_CHAINS-1:0] dir_s, lo_in_s, hi_in_s;
  logic                  shift_fall, latch_fall;
  logic [NSEG-1:0]       chain_all;
  logic [NSEG-1:0]       latch_q;

  ssl_sync #(.W(SW)) u_sync (
    .clk (clk),
    .d   ({hi_in_i, lo_in_i, dir_i, alt_i, latch_stb_i, shift_stb_i}),
    .q   (sync_q)
  );
  assign {hi_in_s, lo_in_s, dir_s, alt_s, latch_s, shift_s} = sync_q;

  ssl_fall_det u_shift_edge (.clk(clk), .rst(rst), .lvl(shift_s), .fall(shift_fall));
  ssl_fall_det u_latch_edge (.clk(clk), .rst(rst), .lvl(latch_s), .fall(latch_fall));

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    ssl_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk    (clk),
      .rst    (rst),
      .step   (shift_fall),
      .dir    (dir_s[c]),
      .lo_in  (lo_in_s[c]),
      .hi_in  (hi_in_s[c]),
      .q      (chain_all[c*CHAIN_LEN +: CHAIN_LEN]),
      .lo_out (lo_out_o[c]),
      .hi_out (hi_out_o[c]),
      .lo_oe  (lo_oe_o[c]),
      .hi_oe  (hi_oe_o[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)             latch_q <= '0;
    else if (latch_fall) latch_q <= chain_all;
  end

  ssl_level_enc #(.N(NSEG)) u_enc (
    .clk  (clk),
    .rst  (rst),
    .alt  (alt_s),
    .lat  (latch_q),
    .code (seg_code_o)
  );
endmodule

// File: rtl/ssl_chk.sv
module ssl_chk #(
  parameter int LEN = 40,
  parameter int NC  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_fall,
  input logic              latch_fall,
  input logic              alt_s,
  input logic [NC-1:0]     dir_s,
  input logic [NC-1:0]     lo_oe,
  input logic [NC-1:0]     hi_oe,
  input logic [NC*LEN-1:0] chain_all,
  input logic [NC*LEN-1:0] latch_q,
  input logic [2*NC*LEN-1:0] code
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (latch_q == '0 && chain_all == '0));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_fall |=> $stable(latch_q));

  // R10
  latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
    latch_fall |=> latch_q == $past(chain_all));

  // R11
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_fall |=> $stable(chain_all));

  for (genvar c = 0; c < NC; c++) begin : g_c
    // R4
    oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot({lo_oe[c], hi_oe[c]}) && hi_oe[c] == !dir_s[c]);
    // R2
    up_shift_chk: assert property (@(posedge clk) disable iff (rst)
      shift_fall && !dir_s[c] |=>
        chain_all[c*LEN+1 +: LEN-1] == $past(chain_all[c*LEN +: LEN-1]));
    // R3
    down_shift_chk: assert property (@(posedge clk) disable iff (rst)
      shift_fall && dir_s[c] |=>
        chain_all[c*LEN +: LEN-1] == $past(chain_all[c*LEN+1 +: LEN-1]));
  end

  for (genvar i = 0; i < NC*LEN; i++) begin : g_s
    // R6
    code_map_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (code[2*i+1] == !$past(latch_q[i]) && code[2*i] == !$past(alt_s)));
  end
endmodule

bind seg_shift_latch ssl_chk #(.LEN(CHAIN_LEN), .NC(NUM_CHAINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shift_fall (shift_fall),
  .latch_fall (latch_fall),
  .alt_s      (alt_s),
  .dir_s      (dir_s),
  .lo_oe      (lo_oe_o),
  .hi_oe      (hi_oe_o),
  .chain_all  (chain_all),
  .latch_q    (latch_q),
  .code       (seg_code_o)
);

// File: tb/test_seg_shift_latch.sv
module test_seg_shift_latch;
  localparam int LEN  = 40;
  localparam int NC   = 2;
  localparam int NSEG = LEN * NC;
  localparam int PH   = 42;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_stb = 1'b0, latch_stb = 1'b0, alt = 1'b0;
  logic [NC-1:0] dir = '0, lo_in = '0, hi_in = '0;
  logic [NC-1:0] lo_out, hi_out, lo_oe, hi_oe;
  logic [2*NSEG-1:0] seg;

  seg_shift_latch #(.CHAIN_LEN(LEN), .NUM_CHAINS(NC)) i_seg_shift_latch (
    .clk(clk), .rst(rst), .shift_stb_i(shift_stb), .latch_stb_i(latch_stb),
    .alt_i(alt), .dir_i(dir), .lo_in_i(lo_in), .hi_in_i(hi_in),
    .lo_out_o(lo_out), .hi_out_o(hi_out), .lo_oe_o(lo_oe), .hi_oe_o(hi_oe),
    .seg_code_o(seg)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [2*NSEG-1:0] exp;
    int                due;
    string             tag;
  } item_t;

  item_t      sb[$];
  int         cyc = 0;
  int         n_cmp = 0, n_bad = 0;
  logic [LEN-1:0] m [NC];
  bit         done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations once they fall due
  always @(negedge clk) begin
    if (sb.size() > 0 && cyc >= sb[0].due) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (seg !== it.exp) begin
        n_bad++;
        $display("FAIL %s codes act=%h exp=%h", it.tag, seg, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2*NSEG-1:0] expect_codes(input logic [NSEG-1:0] bits, input logic a);
    logic [2*NSEG-1:0] r;
    for (int i = 0; i < NSEG; i++)
      r[2*i +: 2] = bits[i] ? (a ? 2'd0 : 2'd1) : (a ? 2'd2 : 2'd3);
    return r;
  endfunction

  function automatic logic [NSEG-1:0] model_bits();
    logic [NSEG-1:0] r;
    for (int c = 0; c < NC; c++) r[c*LEN +: LEN] = m[c];
    return r;
  endfunction

  logic [NSEG-1:0] held;

  task automatic push(input logic [NSEG-1:0] bits, input int delay, input string tag);
    item_t it;
    it.exp = expect_codes(bits, alt);
    it.due = cyc + delay;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic model_shift();
    for (int c = 0; c < NC; c++)
      if (dir[c]) m[c] = {hi_in[c], m[c][LEN-1:1]};
      else        m[c] = {m[c][LEN-2:0], lo_in[c]};
  endtask

  task automatic shift_pulse();
    shift_stb = 1'b1; tick(PH);
    shift_stb = 1'b0; model_shift(); tick(PH);
  endtask

  task automatic latch_pulse(input string tag);
    latch_stb = 1'b1; tick(PH);
    latch_stb = 1'b0;
    held = model_bits();
    push(held, 10, tag);
    tick(PH);
  endtask

  // sends vec so that after LEN shifts chain c holds vec[c] at matching positions
  task automatic load(input logic [LEN-1:0] va, input logic [LEN-1:0] vb);
    for (int k = 0; k < LEN; k++) begin
      for (int c = 0; c < NC; c++) begin
        logic [LEN-1:0] v;
        v = (c == 0) ? va : vb;
        lo_in[c] = v[LEN-1-k];
        hi_in[c] = v[k];
      end
      shift_pulse();
    end
  endtask

  task automatic check_pins(input string tag);
    for (int c = 0; c < NC; c++) begin
      if (dir[c]) begin
        chk(lo_oe[c] == 1'b1 && hi_oe[c] == 1'b0, {tag, " oe"}, {lo_oe[c], hi_oe[c]}, 2);
        chk(lo_out[c] == m[c][0], {tag, " lo_out"}, lo_out[c], m[c][0]);
      end else begin
        chk(hi_oe[c] == 1'b1 && lo_oe[c] == 1'b0, {tag, " oe"}, {lo_oe[c], hi_oe[c]}, 1);
        chk(hi_out[c] == m[c][LEN-1], {tag, " hi_out"}, hi_out[c], m[c][LEN-1]);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < NC; c++) m[c] = '0;
    tick(10);
    // R1: reset with alt=0 and alt=1
    push('0, 0, "R1 alt0");
    check_pins("R4 reset");
    alt = 1'b1; tick(8);
    push('0, 0, "R1 alt1");
    tick(2);
    alt = 1'b0; tick(8);
    rst = 1'b0; tick(5);

    // R2 R6: both chains upward
    dir = 2'b00; tick(5);
    load(40'hA5_3C_0F_F0_81, 40'h12_34_56_78_9A);
    chk(m[0] == 40'hA5_3C_0F_F0_81, "R2 model", 0, 0);
    check_pins("R4 up");
    latch_pulse("R2 R6 up latch");

    // R5: further shifting leaves codes alone
    lo_in = 2'b11;
    shift_pulse(); shift_pulse(); shift_pulse();
    push(held, 0, "R5 hold after shift");
    tick(2);
    latch_pulse("R5 relatch");

    // R3 R8: chain 1 downward while chain 0 upward
    dir = 2'b10; tick(5);
    load(40'hFF_00_C3_5A_01, 40'h80_11_E7_00_3F);
    chk(m[1] == 40'h80_11_E7_00_3F, "R3 model", 0, 0);
    check_pins("R4 mixed");
    latch_pulse("R3 R8 mixed latch");

    // R7: alternation alone
    alt = 1'b1; tick(10);
    push(held, 0, "R7 alt1");
    tick(2);
    alt = 1'b0; tick(10);
    push(held, 0, "R7 alt0");
    tick(2);

    // R9: direction switch keeps contents
    dir = 2'b00; tick(5);
    load(40'h0F_1E_2D_3C_4B, 40'hF0_E1_D2_C3_B4);
    dir = 2'b11; tick(10);
    check_pins("R9 after switch");
    latch_pulse("R9 contents kept");
    hi_in = 2'b01;
    repeat (5) shift_pulse();
    check_pins("R9 new dir");
    latch_pulse("R9 downward shifts");

    // R10: shift and latch fall together
    hi_in = 2'b10;
    shift_stb = 1'b1; latch_stb = 1'b1; tick(PH);
    held = model_bits();
    shift_stb = 1'b0; latch_stb = 1'b0;
    push(held, 10, "R10 coincident pre-shift");
    model_shift();
    tick(PH);
    latch_pulse("R10 post-shift");

    // R11: rising shift edge only, latch while shift high
    hi_in = 2'b11;
    shift_stb = 1'b1; tick(PH);
    latch_pulse("R11 rising no shift");
    shift_stb = 1'b0; model_shift(); tick(PH);
    latch_pulse("R11 one step per fall");

    tick(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule